// File: doc/BRIEF.md
# Stack Machine Integer Execution Unit

This block executes integer bytecodes directly against an operand stack of 32-bit words. Each cycle it can take one already-decoded opcode byte together with two operand bytes. In the same clock edge it rearranges, consumes or extends the stack. The stack lives in flip-flops, and a depth counter tracks how many entries are valid. The supported work falls into four groups: small literal pushes, integer arithmetic, the copy/drop/exchange group, and conditional branch decisions that pop one word and test it against zero.

A branch decision is reported as a one-cycle taken flag. The flag comes with a signed 16-bit offset relative to the PC, built from the two operand bytes with the first byte as the high byte. Instruction fetch and PC update belong to the surrounding core. Every opcode is checked against the current depth before the stack is touched. An opcode that would read below the bottom or grow past the capacity, a remainder by zero, or an unknown opcode raises one error pulse and changes nothing. A side read port returns any word counted down from the top, so the surrounding logic can inspect the stack.

Top module: `stk_bcode_unit`

## Requirements
- R1: While `rst` is high and after it falls, `depth` is 0, every error flag and `br_taken` are 0, and `peek_word` reads 0.
- R2: Add (96), subtract (100) and multiply (104) pop two words and push the low 32 bits of the result, with the word under the top as the left operand. Negate (116) replaces the top with its two's complement negation.
- R3: Remainder (112) pops two words and pushes left minus right times their quotient truncated toward zero, so the result takes the sign of the left operand; a most-negative left operand with a right of -1 gives 0. A zero right operand pulses `err_divzero` and leaves the stack as it was.
- R4: Drop one (87) and drop two (88) remove one or two words. Copy (89) duplicates the top word, copy-pair (92) duplicates the top two words in order, exchange (95) swaps the top two, and no-op (0) changes nothing.
- R5: Opcode 90 turns bottom-to-top A B into B A B. Opcode 91 turns A B C into C A B C.
- R6: Opcode 93 turns A B C into B C A B C. Opcode 94 turns A B C D into C D A B C D.
- R7: Opcodes 153 to 158 pop one word and take the branch when it is =0, !=0, <0, >=0, >0 or <=0 respectively. When the branch is taken, `br_taken` is 1 for one cycle and `br_offset` is {op_hi, op_lo}; otherwise `br_taken` is 0.
- R8: An opcode that needs more words than `depth` holds pulses `err_underflow` and leaves the stack and depth unchanged.
- R9: An opcode that would raise `depth` above 16 pulses `err_overflow` and leaves the stack and depth unchanged; `depth` never exceeds 16.
- R10: Any opcode outside the listed set pulses `err_illegal` and changes nothing. A cycle with `op_valid` low changes nothing.
- R11: A successful opcode changes `depth` by its net word count. Flags last exactly the one cycle after the opcode, and at most one error flag is high at a time.
- R12: Opcodes 2 to 8 push the constants -1 to 5. Opcode 16 pushes `op_hi` sign-extended, and opcode 17 pushes {op_hi, op_lo} sign-extended.
- R13: `peek_word` returns the word `peek_sel` places below the top (0 is the top), or 0 when `peek_sel` is not below `depth`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 8 | Opcode byte |
| op_hi | input | 8 | First operand byte (high byte of 16-bit operands) |
| op_lo | input | 8 | Second operand byte |
| peek_sel | input | 4 | Word position counted from the top |
| depth | output | 5 | Number of valid stack words |
| peek_word | output | 32 | Selected stack word |
| br_taken | output | 1 | Branch taken pulse |
| br_offset | output | 16 | Signed PC-relative offset of the last branch |
| err_underflow | output | 1 | Too few words pulse |
| err_overflow | output | 1 | Capacity exceeded pulse |
| err_divzero | output | 1 | Remainder by zero pulse |
| err_illegal | output | 1 | Unknown opcode pulse |

## Verification
Arithmetic is swept over every ordered pair from a set of operands that includes 0, ±1, both extremes of the 32-bit range and mixed signs. These pairs expose operand order, wraparound, and the truncation direction of the remainder. Each branch condition is tried on zero, positive, negative and extreme values, which separates the six comparisons from one another. Every opcode is tried at depths 0 to 3, which separates the word count each one needs. All 256 opcode values are tried, so the illegal set is checked exactly. The rearrangement opcodes act on distinct full-width words, and the whole stack is read back afterwards, so any misplaced copy shows up. Overflow is tried at depths 14 to 16.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam logic [7:0] OP_NOP        = 8'd0;
  localparam logic [7:0] OP_LIT_M1     = 8'd2;
  localparam logic [7:0] OP_LIT_5      = 8'd8;
  localparam logic [7:0] OP_LIT_BYTE   = 8'd16;
  localparam logic [7:0] OP_LIT_HALF   = 8'd17;
  localparam logic [7:0] OP_DROP1      = 8'd87;
  localparam logic [7:0] OP_DROP2      = 8'd88;
  localparam logic [7:0] OP_COPY1      = 8'd89;
  localparam logic [7:0] OP_COPY1_U2   = 8'd90;
  localparam logic [7:0] OP_COPY1_U3   = 8'd91;
  localparam logic [7:0] OP_COPY2      = 8'd92;
  localparam logic [7:0] OP_COPY2_U3   = 8'd93;
  localparam logic [7:0] OP_COPY2_U4   = 8'd94;
  localparam logic [7:0] OP_EXCH       = 8'd95;
  localparam logic [7:0] OP_ADD        = 8'd96;
  localparam logic [7:0] OP_SUB        = 8'd100;
  localparam logic [7:0] OP_MUL        = 8'd104;
  localparam logic [7:0] OP_REM        = 8'd112;
  localparam logic [7:0] OP_NEG        = 8'd116;
  localparam logic [7:0] OP_BR_EQZ     = 8'd153;
  localparam logic [7:0] OP_BR_NEZ     = 8'd154;
  localparam logic [7:0] OP_BR_LTZ     = 8'd155;
  localparam logic [7:0] OP_BR_GEZ     = 8'd156;
  localparam logic [7:0] OP_BR_GTZ     = 8'd157;
  localparam logic [7:0] OP_BR_LEZ     = 8'd158;

  // Widest rewritten window: four words read, six written.
  localparam int READ_WIN  = 4;
  localparam int WRITE_WIN = 6;

  typedef enum logic [1:0] {K_STACK, K_PUSH, K_ARITH, K_BRANCH} op_kind_e;

  typedef struct packed {
    logic              legal;
    op_kind_e          kind;
    logic [2:0]        need;   // words that must be present
    logic signed [2:0] grow;   // net words added
  } op_info_t;
endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
  import sbu_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);
  always_comb begin
    info = '{legal: 1'b1, kind: K_STACK, need: 3'd0, grow: 3'sd0};
    if (opcode >= OP_LIT_M1 && opcode <= OP_LIT_5) begin
      info.kind = K_PUSH; info.grow = 3'sd1;
    end else begin
      unique case (opcode)
        OP_NOP:      ;
        OP_LIT_BYTE,
        OP_LIT_HALF: begin info.kind = K_PUSH; info.grow = 3'sd1; end
        OP_DROP1:    begin info.need = 3'd1; info.grow = -3'sd1; end
        OP_DROP2:    begin info.need = 3'd2; info.grow = -3'sd2; end
        OP_COPY1:    begin info.need = 3'd1; info.grow = 3'sd1; end
        OP_COPY1_U2: begin info.need = 3'd2; info.grow = 3'sd1; end
        OP_COPY1_U3: begin info.need = 3'd3; info.grow = 3'sd1; end
        OP_COPY2:    begin info.need = 3'd2; info.grow = 3'sd2; end
        OP_COPY2_U3: begin info.need = 3'd3; info.grow = 3'sd2; end
        OP_COPY2_U4: begin info.need = 3'd4; info.grow = 3'sd2; end
        OP_EXCH:     begin info.need = 3'd2; end
        OP_ADD, OP_SUB, OP_MUL, OP_REM: begin
          info.kind = K_ARITH; info.need = 3'd2; info.grow = -3'sd1;
        end
        OP_NEG:      begin info.kind = K_ARITH; info.need = 3'd1; end
        OP_BR_EQZ, OP_BR_NEZ, OP_BR_LTZ, OP_BR_GEZ, OP_BR_GTZ, OP_BR_LEZ: begin
          info.kind = K_BRANCH; info.need = 3'd1; info.grow = -3'sd1;
        end
        default:     info.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sbu_alu.sv
module sbu_alu
  import sbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   opcode,
  input  logic [W-1:0] lhs,      // word under the top
  input  logic [W-1:0] rhs,      // top word
  input  logic [7:0]   lit_hi,
  input  logic [7:0]   lit_lo,
  output logic [W-1:0] result,
  output logic         div_zero,
  output logic         take
);
  logic rhs_zero, rhs_neg;

  assign rhs_zero = (rhs == '0);
  assign rhs_neg  = rhs[W-1];

  always_comb begin
    result   = '0;
    div_zero = 1'b0;
    if (opcode >= OP_LIT_M1 && opcode <= OP_LIT_5) begin
      result = W'($signed({1'b0, opcode}) - 9'sd3);
    end else begin
      case (opcode)
        OP_LIT_BYTE: result = W'($signed(lit_hi));
        OP_LIT_HALF: result = W'($signed({lit_hi, lit_lo}));
        OP_ADD:      result = lhs + rhs;
        OP_SUB:      result = lhs - rhs;
        OP_MUL:      result = lhs * rhs;
        OP_NEG:      result = '0 - rhs;
        OP_REM: begin
          div_zero = rhs_zero;
          if (rhs_zero || rhs == {W{1'b1}}) result = '0;
          else result = W'($signed(lhs) % $signed(rhs));
        end
        default:     result = '0;
      endcase
    end
  end

  always_comb begin
    case (opcode)
      OP_BR_EQZ: take = rhs_zero;
      OP_BR_NEZ: take = !rhs_zero;
      OP_BR_LTZ: take = rhs_neg;
      OP_BR_GEZ: take = !rhs_neg;
      OP_BR_GTZ: take = !rhs_neg && !rhs_zero;
      OP_BR_LEZ: take = rhs_neg || rhs_zero;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbu_window.sv
module sbu_window
  import sbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   opcode,
  input  op_kind_e     kind,
  input  logic [W-1:0] rd  [READ_WIN],   // rd[0] is the top
  input  logic [W-1:0] alu_res,
  output logic [W-1:0] wr  [WRITE_WIN]   // wr[0] becomes the new top
);
  always_comb begin
    for (int k = 0; k < WRITE_WIN; k++) wr[k] = '0;
    if (kind == K_PUSH || kind == K_ARITH) begin
      wr[0] = alu_res;
    end else begin
      case (opcode)
        OP_COPY1: begin wr[0] = rd[0]; wr[1] = rd[0]; end
        OP_EXCH:  begin wr[0] = rd[1]; wr[1] = rd[0]; end
        OP_COPY1_U2: begin
          wr[0] = rd[0]; wr[1] = rd[1]; wr[2] = rd[0];
        end
        OP_COPY1_U3: begin
          wr[0] = rd[0]; wr[1] = rd[1]; wr[2] = rd[2]; wr[3] = rd[0];
        end
        OP_COPY2: begin
          wr[0] = rd[0]; wr[1] = rd[1]; wr[2] = rd[0]; wr[3] = rd[1];
        end
        OP_COPY2_U3: begin
          wr[0] = rd[0]; wr[1] = rd[1]; wr[2] = rd[2];
          wr[3] = rd[0]; wr[4] = rd[1];
        end
        OP_COPY2_U4: begin
          wr[0] = rd[0]; wr[1] = rd[1]; wr[2] = rd[2];
          wr[3] = rd[3]; wr[4] = rd[0]; wr[5] = rd[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_bcode_unit.sv
module stk_bcode_unit
  import sbu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         op_valid,
  input  logic [7:0]                   op_code,
  input  logic [7:0]                   op_hi,
  input  logic [7:0]                   op_lo,
  input  logic [$clog2(DEPTH)-1:0]     peek_sel,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic [W-1:0]                 peek_word,
  output logic                         br_taken,
  output logic [15:0]                  br_offset,
  output logic                         err_underflow,
  output logic                         err_overflow,
  output logic                         err_divzero,
  output logic                         err_illegal
);
  localparam int IW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH+1);

  logic [W-1:0] slots [DEPTH];
  logic [W-1:0] rd    [READ_WIN];
  logic [W-1:0] wr    [WRITE_WIN];
  op_info_t     info;
  logic [W-1:0] alu_res;
  logic         alu_dz, alu_take;
  logic         e_udf, e_ovf, e_dz, e_ill, commit;
  int           sp_i, new_sp, span;

  assign sp_i   = int'(depth);
  assign new_sp = sp_i + int'(info.grow);
  assign span   = int'(info.need) + int'(info.grow);

  // Words near the top, zero where the stack is shallower.
  always_comb begin
    for (int k = 0; k < READ_WIN; k++) begin
      if (k < sp_i) rd[k] = slots[IW'(sp_i - 1 - k)];
      else          rd[k] = '0;
    end
  end

  sbu_decode u_dec (.opcode(op_code), .info(info));

  sbu_alu #(.W(W)) u_alu (
    .opcode(op_code), .lhs(rd[1]), .rhs(rd[0]),
    .lit_hi(op_hi), .lit_lo(op_lo),
    .result(alu_res), .div_zero(alu_dz), .take(alu_take)
  );

  sbu_window #(.W(W)) u_win (
    .opcode(op_code), .kind(info.kind), .rd(rd),
    .alu_res(alu_res), .wr(wr)
  );

  // Priority: unknown opcode, then too few words, then no room, then divisor.
  assign e_ill  = op_valid && !info.legal;
  assign e_udf  = op_valid && info.legal && (sp_i < int'(info.need));
  assign e_ovf  = op_valid && info.legal && !e_udf && (new_sp > DEPTH);
  assign e_dz   = op_valid && info.legal && !e_udf && !e_ovf &&
                  info.kind == K_ARITH && alu_dz;
  assign commit = op_valid && info.legal && !e_udf && !e_ovf && !e_dz;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth         <= '0;
      br_taken      <= 1'b0;
      br_offset     <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_divzero   <= 1'b0;
      err_illegal   <= 1'b0;
    end else begin
      err_underflow <= e_udf;
      err_overflow  <= e_ovf;
      err_divzero   <= e_dz;
      err_illegal   <= e_ill;
      br_taken      <= commit && info.kind == K_BRANCH && alu_take;
      if (commit && info.kind == K_BRANCH) br_offset <= {op_hi, op_lo};
      if (commit) depth <= SPW'(new_sp);
    end
  end

  // One register per stack slot; each slot picks its word from the window.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    int  pos;
    logic hit;
    assign pos = new_sp - 1 - i;
    assign hit = (pos >= 0) && (pos < span);
    always_ff @(posedge clk) begin
      if (commit && hit) slots[i] <= wr[3'(pos)];
    end
  end

  always_comb begin
    if (int'(peek_sel) < sp_i) peek_word = slots[IW'(sp_i - 1 - int'(peek_sel))];
    else                       peek_word = '0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(depth) <= DEPTH); // R9
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_underflow, err_overflow, err_divzero, err_illegal})); // R11
  AST_ERR_HOLDS_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (err_underflow || err_overflow || err_divzero || err_illegal) |-> $stable(depth)); // R8
  AST_BRANCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> !(err_underflow || err_overflow || err_divzero || err_illegal)); // R7
  AST_BRANCH_POPS: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> int'(depth) + 1 == int'($past(depth))); // R7
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(depth) && !err_illegal && !br_taken); // R10
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(depth) <= int'($past(depth)) + 2 && int'(depth) + 2 >= int'($past(depth))); // R11
endmodule

// File: tb/stk_bcode_unit_test.sv
`timescale 1ns/10ps
module stk_bcode_unit_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'd0, op_hi = 8'd0, op_lo = 8'd0;
  logic [3:0]  peek_sel = 4'd0;
  logic [4:0]  depth;
  logic [31:0] peek_word;
  logic        br_taken;
  logic [15:0] br_offset;
  logic        err_underflow, err_overflow, err_divzero, err_illegal;

  stk_bcode_unit uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int ms [DEPTH];
  int msp = 0;
  bit x_ill, x_udf, x_ovf, x_dz, x_br;
  logic [15:0] x_off = 16'd0;

  function automatic bit b_legal(input logic [7:0] op);
    return (op == 0) || (op >= 2 && op <= 8) || op == 16 || op == 17 ||
           (op >= 87 && op <= 96) || op == 100 || op == 104 || op == 112 ||
           op == 116 || (op >= 153 && op <= 158);
  endfunction

  function automatic int b_need(input logic [7:0] op);
    case (op)
      87, 89, 116, 153, 154, 155, 156, 157, 158: return 1;
      88, 90, 92, 95, 96, 100, 104, 112:         return 2;
      91, 93:                                     return 3;
      94:                                         return 4;
      default:                                    return 0;
    endcase
  endfunction

  function automatic int b_grow(input logic [7:0] op);
    if ((op >= 2 && op <= 8) || op == 16 || op == 17) return 1;
    case (op)
      89, 90, 91:                          return 1;
      92, 93, 94:                          return 2;
      87, 96, 100, 104, 112, 153, 154, 155, 156, 157, 158: return -1;
      88:                                  return -2;
      default:                             return 0;
    endcase
  endfunction

  task automatic model_step(input logic [7:0] op, input logic [7:0] hi, input logic [7:0] lo);
    int w0, w1, w2, w3;
    x_ill = 0; x_udf = 0; x_ovf = 0; x_dz = 0; x_br = 0;
    w0 = (msp > 0) ? ms[msp-1] : 0;
    w1 = (msp > 1) ? ms[msp-2] : 0;
    w2 = (msp > 2) ? ms[msp-3] : 0;
    w3 = (msp > 3) ? ms[msp-4] : 0;
    if (!b_legal(op)) begin x_ill = 1; return; end
    if (msp < b_need(op)) begin x_udf = 1; return; end
    if (msp + b_grow(op) > DEPTH) begin x_ovf = 1; return; end
    if (op == 112 && w0 == 0) begin x_dz = 1; return; end
    if (op >= 2 && op <= 8) begin ms[msp] = int'(op) - 3; msp++; return; end
    case (op)
      16: begin ms[msp] = int'($signed(hi)); msp++; end
      17: begin ms[msp] = int'($signed({hi, lo})); msp++; end
      87: msp -= 1;
      88: msp -= 2;
      89: begin ms[msp] = w0; msp++; end
      90: begin ms[msp-2] = w0; ms[msp-1] = w1; ms[msp] = w0; msp++; end
      91: begin ms[msp-3] = w0; ms[msp-2] = w2; ms[msp-1] = w1; ms[msp] = w0; msp++; end
      92: begin ms[msp] = w1; ms[msp+1] = w0; msp += 2; end
      93: begin ms[msp-3] = w1; ms[msp-2] = w0; ms[msp-1] = w2;
                ms[msp] = w1; ms[msp+1] = w0; msp += 2; end
      94: begin ms[msp-4] = w1; ms[msp-3] = w0; ms[msp-2] = w3; ms[msp-1] = w2;
                ms[msp] = w1; ms[msp+1] = w0; msp += 2; end
      95: begin ms[msp-1] = w1; ms[msp-2] = w0; end
      96: begin ms[msp-2] = w1 + w0; msp--; end
      100: begin ms[msp-2] = w1 - w0; msp--; end
      104: begin ms[msp-2] = w1 * w0; msp--; end
      112: begin ms[msp-2] = (w0 == -1) ? 0 : (w1 % w0); msp--; end
      116: ms[msp-1] = -w0;
      default: begin
        if (op >= 153 && op <= 158) begin
          msp--;
          case (op)
            153: x_br = (w0 == 0);
            154: x_br = (w0 != 0);
            155: x_br = (w0 < 0);
            156: x_br = (w0 >= 0);
            157: x_br = (w0 > 0);
            default: x_br = (w0 <= 0);
          endcase
          if (x_br) x_off = {hi, lo};
        end
      end
    endcase
  endtask

  task automatic compare(input string req);
    bit bad;
    checks++;
    if ({err_illegal, err_underflow, err_overflow, err_divzero, br_taken} !==
        {x_ill, x_udf, x_ovf, x_dz, x_br} || (x_br && br_offset !== x_off)) begin
      errors++;
      $display("FAIL %s flags ill/udf/ovf/dz/br/off actual %b%b%b%b%b/%h expected %b%b%b%b%b/%h",
               req, err_illegal, err_underflow, err_overflow, err_divzero, br_taken, br_offset,
               x_ill, x_udf, x_ovf, x_dz, x_br, x_off);
    end
    checks++;
    if (int'(depth) != msp) begin
      errors++;
      $display("FAIL %s depth actual %0d expected %0d", req, depth, msp);
    end
    checks++;
    bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      int exp_w;
      peek_sel = 4'(k);
      #0.1;
      exp_w = (k < msp) ? ms[msp-1-k] : 0;
      if (!bad && peek_word !== 32'(exp_w)) begin
        bad = 1;
        errors++;
        $display("FAIL %s (R13) word %0d below top actual %h expected %h",
                 req, k, peek_word, 32'(exp_w));
      end
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [7:0] hi, input logic [7:0] lo,
                       input string req);
    op_valid = 1'b1; op_code = op; op_hi = hi; op_lo = lo;
    model_step(op, hi, lo);
    @(negedge clk);
    op_valid = 1'b0;
    compare(req);
  endtask

  task automatic push32(input int v, input string req);
    logic [15:0] l16, h16;
    int rest;
    l16  = v[15:0];
    rest = v - int'($signed(l16));
    h16  = rest[31:16];
    do_op(8'd17, h16[15:8], h16[7:0], req);
    do_op(8'd17, 8'h01, 8'h00, req);
    do_op(8'd104, 8'd0, 8'd0, req);
    do_op(8'd17, 8'h01, 8'h00, req);
    do_op(8'd104, 8'd0, 8'd0, req);
    do_op(8'd17, l16[15:8], l16[7:0], req);
    do_op(8'd96, 8'd0, 8'd0, req);
  endtask

  task automatic clear_stack();
    while (msp > 0) do_op(8'd87, 8'd0, 8'd0, "R4");
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) do_op(8'd17, 8'(k + 3), 8'(k * 37 + 5), "R12");
  endtask

  int vals [8] = '{0, 1, -1, 7, -13, 32'h7fffffff, 32'h80000000, 123456789};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    x_ill = 0; x_udf = 0; x_ovf = 0; x_dz = 0; x_br = 0;
    compare("R1");
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    // R12: literal pushes
    for (int op = 2; op <= 8; op++) do_op(8'(op), 8'd0, 8'd0, "R12");
    do_op(8'd16, 8'h80, 8'h55, "R12");
    do_op(8'd16, 8'h7f, 8'h00, "R12");
    do_op(8'd17, 8'hff, 8'h38, "R12");
    do_op(8'd17, 8'h12, 8'h34, "R12");
    clear_stack();

    // R10/R11: idle cycle leaves everything in place and flags low
    fill(3);
    op_code = 8'd89; op_valid = 1'b0;
    x_ill = 0; x_udf = 0; x_ovf = 0; x_dz = 0; x_br = 0;
    @(negedge clk);
    compare("R10");
    do_op(8'd0, 8'd0, 8'd0, "R4");
    clear_stack();

    // R2 / R3: arithmetic sweep over operand pairs
    foreach (vals[a]) begin
      push32(vals[a], "R2");
      do_op(8'd116, 8'd0, 8'd0, "R2");
      do_op(8'd87, 8'd0, 8'd0, "R4");
      foreach (vals[b]) begin
        push32(vals[a], "R2");
        push32(vals[b], "R2");
        do_op(8'd92, 8'd0, 8'd0, "R4");
        do_op(8'd92, 8'd0, 8'd0, "R4");
        do_op(8'd96, 8'd0, 8'd0, "R2");
        do_op(8'd87, 8'd0, 8'd0, "R4");
        do_op(8'd100, 8'd0, 8'd0, "R2");
        do_op(8'd87, 8'd0, 8'd0, "R4");
        do_op(8'd92, 8'd0, 8'd0, "R4");
        do_op(8'd104, 8'd0, 8'd0, "R2");
        do_op(8'd87, 8'd0, 8'd0, "R4");
        do_op(8'd112, 8'd0, 8'd0, "R3");
        clear_stack();
      end
    end

    // R4 / R5 / R6: rearrangement on distinct words
    foreach (uut.u_win.wr[j]) ;
    for (int op = 87; op <= 95; op++) begin
      push32(32'h1111_aaaa, "R12");
      push32(32'h2222_bbbb, "R12");
      push32(32'h3333_cccc, "R12");
      push32(32'h4444_dddd, "R12");
      push32(32'h5555_eeee, "R12");
      do_op(8'(op), 8'd0, 8'd0, (op >= 93) ? "R6" : (op >= 90 && op <= 91) ? "R5" : "R4");
      clear_stack();
    end

    // R7: branch decisions
    foreach (vals[a]) begin
      for (int op = 153; op <= 158; op++) begin
        push32(vals[a], "R12");
        do_op(8'(op), (op % 2) ? 8'hff : 8'h12, (op % 2) ? 8'hf0 : 8'h34, "R7");
      end
    end

    // R8: every legal opcode at depths 0..3 that needs more words
    for (int d = 0; d <= 3; d++) begin
      for (int op = 0; op < 256; op++) begin
        if (b_legal(8'(op)) && b_need(8'(op)) > d) begin
          fill(d);
          do_op(8'(op), 8'd0, 8'd0, "R8");
          clear_stack();
        end
      end
    end

    // R9: growth near capacity
    for (int d = 14; d <= 16; d++) begin
      for (int op = 89; op <= 94; op++) begin
        fill(d);
        do_op(8'(op), 8'd0, 8'd0, "R9");
        clear_stack();
      end
    end
    fill(16);
    do_op(8'd17, 8'h00, 8'h01, "R9");
    do_op(8'd5, 8'd0, 8'd0, "R9");
    clear_stack();

    // R10: exhaustive opcode sweep for the illegal set
    fill(4);
    for (int op = 0; op < 256; op++)
      if (!b_legal(8'(op))) do_op(8'(op), 8'hab, 8'hcd, "R10");
    // R11: flags fall back after an error
    do_op(8'd0, 8'd0, 8'd0, "R11");
    clear_stack();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule